// File: doc/BRIEF.md
# Low-Speed USB Endpoint Handshake Responder

This block chooses how a low-speed USB device answers each token that a packet decoder has already decoded. It serves three endpoints. Endpoint 0 carries control traffic in both directions. Endpoints 1 and 2 carry interrupt traffic. The block combines several inputs to make each decision:

- the token kind, address and endpoint number;
- the data-packet strobe, its PID parity, its length and its CRC result;
- the host's ACK after an IN packet;
- level flags from the surrounding logic: the device address, a busy flag for the shared OUT buffer, and a per-endpoint "IN buffer loaded" flag.

Two pieces of state live inside the block: the per-direction endpoint enables and the stall bits. The local controller writes both through simple write strobes. The block also updates some state on its own. A SETUP token clears the endpoint-0 stall bits, and the end of a bus reset turns on both endpoint-0 directions.

Each outcome is reported as one registered pulse in the cycle after the input strobe. The outcome is one of three things: a handshake code, an order to send the loaded IN packet, or silence. For an accepted OUT or SETUP packet, the block latches the byte count, the endpoint code and the toggle bit, and raises a done flag. A done flag is also raised when the host acknowledges an IN packet. The controller clears the done flags with clear strobes. The PHY, the CRC engines and the FIFO storage sit outside the block.

Top module: `usb_ep_responder`

## Requirements
- R1: A token whose address differs from `dev_addr` gets no handshake, no IN send and no flush. It changes no block state, and a data packet that follows it is ignored as well.
- R2: After `rst` all enables are 0. In the first cycle in which `bus_reset` is seen low after being high, the EP0 IN and EP0 OUT enables become 1. Other enables change only through `en_we`, where `en_wdata[k]` is the IN enable and `en_wdata[NUM_EP+k]` is the OUT enable of endpoint k. A token to a disabled endpoint is ignored, as is a token to an endpoint number of NUM_EP or more, a SETUP to a nonzero endpoint, and token kind 3. Token kinds are 0 = OUT, 1 = IN, 2 = SETUP.
- R3: An accepted IN token that is not stalled has one of two outcomes. If the endpoint's `in_loaded` bit is 0, the block answers NAK (`hs_code` 2). If the bit is 1, including for a zero-length packet, the block pulses `in_send` with `in_send_ep` equal to the endpoint.
- R4: After an `in_send`, a `host_ack` that arrives before any other token sets `in_done_ep0` for endpoint 0, or `in_done_ep12` for endpoints 1 and 2. Without that ACK, neither flag is set.
- R5: An accepted SETUP token pulses `flush_in` one cycle later and clears both EP0 stall bits. It is never answered with STALL or NAK.
- R6: While `out_busy` is 1, a valid SETUP data packet gets no handshake and is not recorded. A valid OUT data packet gets NAK and is not recorded.
- R7: The stall bits are laid out in `stall_wdata` as follows: [0] stalls EP0 OUT, [1] stalls EP0 IN, and [k+1] stalls both directions of endpoint k for k ≥ 1. A stalled IN token, or a valid data packet after a stalled OUT token, gets STALL (`hs_code` 3). STALL takes precedence over NAK.
- R8: A valid OUT or SETUP data packet that is neither stalled nor blocked by busy gets ACK (`hs_code` 1). It also latches four things: `out_count` set to the length, `out_ep` set to the endpoint code (0, 1 or 2), `out_toggle` set to `data_odd` (1 = DATA1), and `setup_flag` set for SETUP. Finally it sets `out_done`.
- R9: A data packet with `data_crc_ok` at 0, or with a length above MAX_PKT (8), gets no handshake and leaves the recorded fields and flags unchanged.
- R10: `out_done_clr` clears `out_done` and `setup_flag`. `in_done_clr[0]` clears `in_done_ep0`, and `in_done_clr[1]` clears `in_done_ep12`.
- R11: After `rst` no output pulses and all flags and recorded fields are 0. While `bus_reset` is high, all enables and stall bits are cleared and any pending transaction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | ADDR_W (7) | Device address from the register file |
| bus_reset | input | 1 | Bus reset level from the line monitor |
| en_we | input | 1 | Write strobe for the enables |
| en_wdata | input | 2*NUM_EP (6) | [k] IN enable, [NUM_EP+k] OUT enable of endpoint k |
| stall_we | input | 1 | Write strobe for the stall bits |
| stall_wdata | input | NUM_EP+1 (4) | Stall bits, layout as in R7 |
| out_busy | input | 1 | Shared OUT buffer still holds unread data |
| in_loaded | input | NUM_EP (3) | Per-endpoint IN buffer holds a packet |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP, 3 other |
| tok_addr | input | ADDR_W (7) | Token address |
| tok_ep | input | EP_W (2) | Token endpoint number |
| data_valid | input | 1 | End-of-data-packet strobe |
| data_odd | input | 1 | Data PID parity, 1 = DATA1 |
| data_len | input | LEN_W (4) | Payload byte count |
| data_crc_ok | input | 1 | Data CRC check passed |
| host_ack | input | 1 | Host ACK received after an IN packet |
| in_done_clr | input | 2 | [0] clears EP0 IN done, [1] clears EP1/2 IN done |
| out_done_clr | input | 1 | Clears OUT done and the SETUP flag |
| hs_valid | output | 1 | Handshake pulse |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| in_send | output | 1 | Send the loaded IN packet |
| in_send_ep | output | EP_W (2) | Endpoint of the IN packet to send |
| flush_in | output | 1 | Flush every IN buffer |
| in_done_ep0 | output | 1 | EP0 IN packet acknowledged |
| in_done_ep12 | output | 1 | EP1 or EP2 IN packet acknowledged |
| out_done | output | 1 | OUT or SETUP data recorded |
| setup_flag | output | 1 | Last recorded packet came from SETUP |
| out_count | output | LEN_W (4) | Recorded byte count |
| out_ep | output | EP_W (2) | Recorded endpoint code |
| out_toggle | output | 1 | Recorded data toggle |

## Verification
The bench targets several corner cases. Each one is listed with the bug it would expose:

- **Busy OUT buffer.** SETUP and OUT are sent with `out_busy` high. A design that treated busy the same for both kinds would NAK a SETUP, or stay silent to an OUT.
- **Stalls with SETUP.** A SETUP is sent while both EP0 stall bits are set. A design that did not clear the stalls would keep stalling the IN tokens that follow, and one that stalled the SETUP itself would answer STALL.
- **Bad data packets.** Packets with a bad CRC or with nine or ten bytes are sent. A careless design would ACK them or overwrite the recorded count.
- **Lost IN acknowledge.** A host ACK is dropped, or arrives after an intervening token. The wrong design would set a done flag anyway.
- **Disabled endpoints and foreign addresses.** Tokens to disabled endpoints, to endpoint 3 and to other addresses are followed by data packets. A design that did not filter them would produce handshakes or records.

// File: rtl/usb_resp_pkg.sv
package usb_resp_pkg;

  typedef enum logic [1:0] {
    TK_OUT   = 2'd0,
    TK_IN    = 2'd1,
    TK_SETUP = 2'd2,
    TK_OTHER = 2'd3
  } tok_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_DATA = 2'd1,
    ST_WAIT_ACK  = 2'd2
  } resp_st_e;

endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs #(
  parameter int NUM_EP = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_reset,
  input  logic                  en_we,
  input  logic [2*NUM_EP-1:0]   en_wdata,
  input  logic                  stall_we,
  input  logic [NUM_EP:0]       stall_wdata,
  input  logic                  setup_clr,
  output logic [NUM_EP-1:0]     en_in,
  output logic [NUM_EP-1:0]     en_out,
  output logic [NUM_EP-1:0]     stall_in,
  output logic [NUM_EP-1:0]     stall_out
);

  logic              bus_reset_q;
  logic [NUM_EP-1:0] en_in_q;
  logic [NUM_EP-1:0] en_out_q;
  // [0] EP0 OUT, [1] EP0 IN, [k+1] endpoint k both directions
  logic [NUM_EP:0]   stall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_reset_q <= 1'b0;
      en_in_q     <= '0;
      en_out_q    <= '0;
      stall_q     <= '0;
    end else begin
      bus_reset_q <= bus_reset;
      if (bus_reset) begin
        en_in_q  <= '0;
        en_out_q <= '0;
        stall_q  <= '0;
      end else begin
        if (en_we) begin
          en_in_q  <= en_wdata[NUM_EP-1:0];
          en_out_q <= en_wdata[2*NUM_EP-1:NUM_EP];
        end
        // end of bus reset: control endpoint comes up in both directions
        if (bus_reset_q) begin
          en_in_q[0]  <= 1'b1;
          en_out_q[0] <= 1'b1;
        end
        if (stall_we) stall_q <= stall_wdata;
        if (setup_clr) stall_q[1:0] <= 2'b00;
      end
    end
  end

  assign en_in        = en_in_q;
  assign en_out       = en_out_q;
  assign stall_out[0] = stall_q[0];
  assign stall_in[0]  = stall_q[1];

  for (genvar k = 1; k < NUM_EP; k++) begin : g_ep_stall
    assign stall_out[k] = stall_q[k+1];
    assign stall_in[k]  = stall_q[k+1];
  end

endmodule

// File: rtl/ep_token_decode.sv
module ep_token_decode
  import usb_resp_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NUM_EP = 3,
  parameter int EP_W   = 2
) (
  input  logic              tok_valid,
  input  logic [1:0]        tok_pid,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [NUM_EP-1:0] en_in,
  input  logic [NUM_EP-1:0] en_out,
  input  logic [NUM_EP-1:0] stall_in,
  input  logic [NUM_EP-1:0] stall_out,
  output logic              tok_hit,
  output logic              tok_stall,
  output logic              tok_setup,
  output logic              tok_in
);

  localparam logic [EP_W:0] EP_LIM = (EP_W+1)'(NUM_EP);

  tok_e kind;
  logic addr_ok, ep_ok, kind_ok, en_bit, st_bit;

  always_comb begin
    kind    = tok_e'(tok_pid);
    addr_ok = (tok_addr == dev_addr);
    ep_ok   = ({1'b0, tok_ep} < EP_LIM);
    en_bit  = 1'b0;
    st_bit  = 1'b0;
    if (ep_ok) begin
      if (kind == TK_IN) begin
        en_bit = en_in[tok_ep];
        st_bit = stall_in[tok_ep];
      end else begin
        en_bit = en_out[tok_ep];
        st_bit = stall_out[tok_ep];
      end
    end
    kind_ok   = (kind == TK_IN) || (kind == TK_OUT) ||
                ((kind == TK_SETUP) && (tok_ep == '0));
    tok_hit   = tok_valid && addr_ok && ep_ok && en_bit && kind_ok;
    tok_setup = (kind == TK_SETUP);
    tok_in    = (kind == TK_IN);
    // control setup is never refused
    tok_stall = st_bit && (kind != TK_SETUP);
  end

endmodule

// File: rtl/ep_out_record.sv
module ep_out_record #(
  parameter int LEN_W = 4,
  parameter int EP_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [LEN_W-1:0] len,
  input  logic [EP_W-1:0]  ep,
  input  logic             toggle,
  input  logic             is_setup,
  input  logic             clr,
  output logic [LEN_W-1:0] out_count,
  output logic [EP_W-1:0]  out_ep,
  output logic             out_toggle,
  output logic             out_done,
  output logic             setup_flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_count  <= '0;
      out_ep     <= '0;
      out_toggle <= 1'b0;
      out_done   <= 1'b0;
      setup_flag <= 1'b0;
    end else if (commit) begin
      out_count  <= len;
      out_ep     <= ep;
      out_toggle <= toggle;
      out_done   <= 1'b1;
      setup_flag <= is_setup;
    end else if (clr) begin
      out_done   <= 1'b0;
      setup_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_ep_responder.sv
module usb_ep_responder
  import usb_resp_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int NUM_EP  = 3,
  parameter int MAX_PKT = 8,
  parameter int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  parameter int LEN_W   = $clog2(MAX_PKT + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   dev_addr,
  input  logic                bus_reset,
  input  logic                en_we,
  input  logic [2*NUM_EP-1:0] en_wdata,
  input  logic                stall_we,
  input  logic [NUM_EP:0]     stall_wdata,
  input  logic                out_busy,
  input  logic [NUM_EP-1:0]   in_loaded,
  input  logic                tok_valid,
  input  logic [1:0]          tok_pid,
  input  logic [ADDR_W-1:0]   tok_addr,
  input  logic [EP_W-1:0]     tok_ep,
  input  logic                data_valid,
  input  logic                data_odd,
  input  logic [LEN_W-1:0]    data_len,
  input  logic                data_crc_ok,
  input  logic                host_ack,
  input  logic [1:0]          in_done_clr,
  input  logic                out_done_clr,
  output logic                hs_valid,
  output logic [1:0]          hs_code,
  output logic                in_send,
  output logic [EP_W-1:0]     in_send_ep,
  output logic                flush_in,
  output logic                in_done_ep0,
  output logic                in_done_ep12,
  output logic                out_done,
  output logic                setup_flag,
  output logic [LEN_W-1:0]    out_count,
  output logic [EP_W-1:0]     out_ep,
  output logic                out_toggle
);

  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PKT);

  logic [NUM_EP-1:0] en_in, en_out, stall_in, stall_out;
  logic              tok_hit, tok_stall, tok_setup, tok_in;
  logic              setup_clr;

  ep_cfg_regs #(.NUM_EP(NUM_EP)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .bus_reset   (bus_reset),
    .en_we       (en_we),
    .en_wdata    (en_wdata),
    .stall_we    (stall_we),
    .stall_wdata (stall_wdata),
    .setup_clr   (setup_clr),
    .en_in       (en_in),
    .en_out      (en_out),
    .stall_in    (stall_in),
    .stall_out   (stall_out)
  );

  ep_token_decode #(.ADDR_W(ADDR_W), .NUM_EP(NUM_EP), .EP_W(EP_W)) u_dec (
    .tok_valid (tok_valid),
    .tok_pid   (tok_pid),
    .tok_addr  (tok_addr),
    .tok_ep    (tok_ep),
    .dev_addr  (dev_addr),
    .en_in     (en_in),
    .en_out    (en_out),
    .stall_in  (stall_in),
    .stall_out (stall_out),
    .tok_hit   (tok_hit),
    .tok_stall (tok_stall),
    .tok_setup (tok_setup),
    .tok_in    (tok_in)
  );

  resp_st_e        st_q, st_nxt;
  logic [EP_W-1:0] ep_q;
  logic            setup_q, stall_pend_q;
  hs_e             hs_nxt;
  logic            send_nxt, commit, ack_ep0, ack_ep12, len_ok;

  always_comb begin
    st_nxt    = st_q;
    hs_nxt    = HS_NONE;
    send_nxt  = 1'b0;
    commit    = 1'b0;
    setup_clr = 1'b0;
    ack_ep0   = 1'b0;
    ack_ep12  = 1'b0;
    len_ok    = (data_len <= LEN_MAX);

    case (st_q)
      ST_WAIT_DATA: if (data_valid) begin
        st_nxt = ST_IDLE;
        if (data_crc_ok && len_ok) begin
          if (setup_q) begin
            if (!out_busy) begin
              hs_nxt = HS_ACK;
              commit = 1'b1;
            end
          end else if (stall_pend_q) begin
            hs_nxt = HS_STALL;
          end else if (out_busy) begin
            hs_nxt = HS_NAK;
          end else begin
            hs_nxt = HS_ACK;
            commit = 1'b1;
          end
        end
      end
      ST_WAIT_ACK: if (host_ack) begin
        st_nxt = ST_IDLE;
        if (ep_q == '0) ack_ep0 = 1'b1;
        else            ack_ep12 = 1'b1;
      end
      default: ;
    endcase

    // any new token ends whatever transaction was pending
    if (tok_valid) begin
      st_nxt = ST_IDLE;
      if (tok_hit) begin
        if (tok_in) begin
          if (tok_stall)              hs_nxt = HS_STALL;
          else if (in_loaded[tok_ep]) begin
            send_nxt = 1'b1;
            st_nxt   = ST_WAIT_ACK;
          end else                    hs_nxt = HS_NAK;
        end else begin
          st_nxt    = ST_WAIT_DATA;
          setup_clr = tok_setup;
        end
      end
    end

    if (bus_reset) begin
      st_nxt    = ST_IDLE;
      hs_nxt    = HS_NONE;
      send_nxt  = 1'b0;
      commit    = 1'b0;
      setup_clr = 1'b0;
      ack_ep0   = 1'b0;
      ack_ep12  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      ep_q         <= '0;
      setup_q      <= 1'b0;
      stall_pend_q <= 1'b0;
      hs_valid     <= 1'b0;
      hs_code      <= HS_NONE;
      in_send      <= 1'b0;
      in_send_ep   <= '0;
      flush_in     <= 1'b0;
      in_done_ep0  <= 1'b0;
      in_done_ep12 <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      hs_valid <= (hs_nxt != HS_NONE);
      hs_code  <= hs_nxt;
      in_send  <= send_nxt;
      flush_in <= setup_clr;
      if (tok_hit) begin
        ep_q         <= tok_ep;
        setup_q      <= tok_setup;
        stall_pend_q <= tok_stall;
      end
      if (send_nxt) in_send_ep <= tok_ep;
      if (ack_ep0)             in_done_ep0 <= 1'b1;
      else if (in_done_clr[0]) in_done_ep0 <= 1'b0;
      if (ack_ep12)            in_done_ep12 <= 1'b1;
      else if (in_done_clr[1]) in_done_ep12 <= 1'b0;
    end
  end

  ep_out_record #(.LEN_W(LEN_W), .EP_W(EP_W)) u_rec (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .len        (data_len),
    .ep         (ep_q),
    .toggle     (data_odd),
    .is_setup   (setup_q),
    .clr        (out_done_clr),
    .out_count  (out_count),
    .out_ep     (out_ep),
    .out_toggle (out_toggle),
    .out_done   (out_done),
    .setup_flag (setup_flag)
  );

endmodule

// File: rtl/usb_ep_responder_chk.sv
module usb_ep_responder_chk #(
  parameter int ADDR_W  = 7,
  parameter int NUM_EP  = 3,
  parameter int MAX_PKT = 8,
  parameter int LEN_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_reset,
  input logic              tok_valid,
  input logic [ADDR_W-1:0] tok_addr,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              data_valid,
  input logic              host_ack,
  input logic              hs_valid,
  input logic              in_send,
  input logic              flush_in,
  input logic              in_done_ep0,
  input logic              out_done,
  input logic [LEN_W-1:0]  out_count,
  input logic [NUM_EP-1:0] en_in,
  input logic [NUM_EP-1:0] en_out,
  input logic [NUM_EP-1:0] stall_in,
  input logic [NUM_EP-1:0] stall_out
);

  // R1
  addr_miss_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && (tok_addr != dev_addr) && !data_valid && !host_ack)
      |=> (!hs_valid && !in_send && !flush_in));

  // R2
  bus_reset_end_en_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_reset) |=> (en_in[0] && en_out[0]));

  // R4
  in_done_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_done_ep0) |-> $past(host_ack));

  // R5
  setup_clears_stall_chk: assert property (@(posedge clk) disable iff (rst)
    flush_in |-> (!stall_in[0] && !stall_out[0]));

  // R8
  out_count_range_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_done) |-> ((out_count <= LEN_W'(MAX_PKT)) && $past(data_valid)));

  // R3
  one_reply_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_valid && in_send));

endmodule

bind usb_ep_responder usb_ep_responder_chk #(
  .ADDR_W(ADDR_W), .NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT), .LEN_W(LEN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_reset   (bus_reset),
  .tok_valid   (tok_valid),
  .tok_addr    (tok_addr),
  .dev_addr    (dev_addr),
  .data_valid  (data_valid),
  .host_ack    (host_ack),
  .hs_valid    (hs_valid),
  .in_send     (in_send),
  .flush_in    (flush_in),
  .in_done_ep0 (in_done_ep0),
  .out_done    (out_done),
  .out_count   (out_count),
  .en_in       (en_in),
  .en_out      (en_out),
  .stall_in    (stall_in),
  .stall_out   (stall_out)
);

// File: tb/usb_ep_responder_test.sv
module usb_ep_responder_test;

  localparam int DEV = 7'h2A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] dev_addr = 7'(DEV);
  logic       bus_reset = 1'b0;
  logic       en_we = 1'b0;
  logic [5:0] en_wdata = '0;
  logic       stall_we = 1'b0;
  logic [3:0] stall_wdata = '0;
  logic       out_busy = 1'b0;
  logic [2:0] in_loaded = '0;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_pid = '0;
  logic [6:0] tok_addr = '0;
  logic [1:0] tok_ep = '0;
  logic       data_valid = 1'b0;
  logic       data_odd = 1'b0;
  logic [3:0] data_len = '0;
  logic       data_crc_ok = 1'b0;
  logic       host_ack = 1'b0;
  logic [1:0] in_done_clr = '0;
  logic       out_done_clr = 1'b0;
  logic       hs_valid, in_send, flush_in, in_done_ep0, in_done_ep12;
  logic       out_done, setup_flag, out_toggle;
  logic [1:0] hs_code, in_send_ep, out_ep;
  logic [3:0] out_count;

  usb_ep_responder uut (
    .clk(clk), .rst(rst), .dev_addr(dev_addr), .bus_reset(bus_reset),
    .en_we(en_we), .en_wdata(en_wdata), .stall_we(stall_we),
    .stall_wdata(stall_wdata), .out_busy(out_busy), .in_loaded(in_loaded),
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr),
    .tok_ep(tok_ep), .data_valid(data_valid), .data_odd(data_odd),
    .data_len(data_len), .data_crc_ok(data_crc_ok), .host_ack(host_ack),
    .in_done_clr(in_done_clr), .out_done_clr(out_done_clr),
    .hs_valid(hs_valid), .hs_code(hs_code), .in_send(in_send),
    .in_send_ep(in_send_ep), .flush_in(flush_in), .in_done_ep0(in_done_ep0),
    .in_done_ep12(in_done_ep12), .out_done(out_done), .setup_flag(setup_flag),
    .out_count(out_count), .out_ep(out_ep), .out_toggle(out_toggle)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model state
  bit [2:0] m_en_in, m_en_out;
  bit [3:0] m_stall;
  bit m_done0, m_done12, m_out_done, m_setup, m_tog;
  int m_cnt, m_ep;
  bit pend_data, pend_setup, pend_stall, pend_in;
  int pend_ep;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all(string req, int e_hs, bit e_send, int e_ep, bit e_flush);
    check(req, hs_valid, e_hs != 0);
    if (e_hs != 0) check(req, hs_code, e_hs);
    check(req, in_send, e_send);
    if (e_send) check(req, in_send_ep, e_ep);
    check(req, flush_in, e_flush);
    check("R4/R10 in_done_ep0", in_done_ep0, m_done0);
    check("R4/R10 in_done_ep12", in_done_ep12, m_done12);
    check("R8/R10 out_done", out_done, m_out_done);
    check("R8/R10 setup_flag", setup_flag, m_setup);
    check("R8 out_count", out_count, m_cnt);
    check("R8 out_ep", out_ep, m_ep);
    check("R8 out_toggle", out_toggle, m_tog);
  endtask

  function automatic bit m_hit(int pid, int addr, int ep);
    if (addr != DEV || ep >= 3 || pid == 3) return 0;
    if (pid == 2 && ep != 0) return 0;
    if (pid == 1) return m_en_in[ep];
    return m_en_out[ep];
  endfunction

  function automatic bit m_stalled(int pid, int ep);
    if (ep == 0) return (pid == 1) ? m_stall[1] : m_stall[0];
    return m_stall[ep+1];
  endfunction

  task automatic token(string req, int pid, int addr, int ep);
    int e_hs = 0; bit e_send = 0, e_flush = 0;
    @(negedge clk);
    tok_valid = 1; tok_pid = 2'(pid); tok_addr = 7'(addr); tok_ep = 2'(ep);
    pend_data = 0; pend_in = 0;
    if (m_hit(pid, addr, ep)) begin
      if (pid == 1) begin
        if (m_stalled(pid, ep)) e_hs = 3;
        else if (in_loaded[ep]) begin e_send = 1; pend_in = 1; pend_ep = ep; end
        else e_hs = 2;
      end else begin
        pend_data = 1; pend_ep = ep; pend_setup = (pid == 2);
        pend_stall = (pid == 2) ? 0 : m_stalled(pid, ep);
        if (pid == 2) begin e_flush = 1; m_stall[1:0] = 2'b00; end
      end
    end
    @(negedge clk);
    tok_valid = 0;
    compare_all(req, e_hs, e_send, ep, e_flush);
  endtask

  task automatic data(string req, int len, bit odd, bit crc);
    int e_hs = 0; bit rec = 0;
    @(negedge clk);
    data_valid = 1; data_len = 4'(len); data_odd = odd; data_crc_ok = crc;
    if (pend_data) begin
      pend_data = 0;
      if (crc && len <= 8) begin
        if (pend_setup) begin
          if (!out_busy) begin e_hs = 1; rec = 1; end
        end else if (pend_stall) e_hs = 3;
        else if (out_busy) e_hs = 2;
        else begin e_hs = 1; rec = 1; end
      end
    end
    if (rec) begin
      m_cnt = len; m_ep = pend_ep; m_tog = odd; m_out_done = 1; m_setup = pend_setup;
    end
    @(negedge clk);
    data_valid = 0;
    compare_all(req, e_hs, 0, 0, 0);
  endtask

  task automatic ack(string req);
    @(negedge clk);
    host_ack = 1;
    if (pend_in) begin
      pend_in = 0;
      if (pend_ep == 0) m_done0 = 1; else m_done12 = 1;
    end
    @(negedge clk);
    host_ack = 0;
    compare_all(req, 0, 0, 0, 0);
  endtask

  task automatic wr_en(bit [5:0] v);
    @(negedge clk); en_we = 1; en_wdata = v;
    @(negedge clk); en_we = 0;
    m_en_in = v[2:0]; m_en_out = v[5:3];
  endtask

  task automatic wr_stall(bit [3:0] v);
    @(negedge clk); stall_we = 1; stall_wdata = v;
    @(negedge clk); stall_we = 0;
    m_stall = v;
  endtask

  task automatic clr(string req, bit [1:0] ic, bit oc);
    @(negedge clk); in_done_clr = ic; out_done_clr = oc;
    if (ic[0]) m_done0 = 0;
    if (ic[1]) m_done12 = 0;
    if (oc) begin m_out_done = 0; m_setup = 0; end
    @(negedge clk); in_done_clr = 0; out_done_clr = 0;
    compare_all(req, 0, 0, 0, 0);
  endtask

  task automatic do_bus_reset();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); @(negedge clk); bus_reset = 0;
    @(negedge clk);
    m_en_in = 3'b001; m_en_out = 3'b001; m_stall = 0;
    pend_data = 0; pend_in = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare_all("R11 reset", 0, 0, 0, 0);

    // before any bus reset: nothing enabled
    token("R2 disabled EP0 IN", 1, DEV, 0);
    token("R2 disabled EP0 OUT", 0, DEV, 0);
    data("R2 data after ignored token", 4, 0, 1);

    do_bus_reset();
    token("R3 EP0 IN empty NAK", 1, DEV, 0);
    in_loaded = 3'b001;
    token("R3 EP0 IN loaded send", 1, DEV, 0);
    ack("R4 EP0 done");
    clr("R10 clear ep0 done", 2'b01, 0);

    token("R5 SETUP token", 2, DEV, 0);
    data("R8 SETUP 8 bytes", 8, 0, 1);
    clr("R10 clear out done", 2'b00, 1);
    token("R8 OUT", 0, DEV, 0);
    data("R8 OUT zero length DATA1", 0, 1, 1);

    out_busy = 1;
    token("R6 SETUP busy", 2, DEV, 0);
    data("R6 SETUP busy silent", 3, 0, 1);
    token("R6 OUT busy", 0, DEV, 0);
    data("R6 OUT busy NAK", 3, 1, 1);
    out_busy = 0;

    wr_stall(4'b0011);
    token("R7 EP0 IN stall", 1, DEV, 0);
    out_busy = 1;
    token("R7 EP0 OUT stall", 0, DEV, 0);
    data("R7 stall beats NAK", 2, 0, 1);
    out_busy = 0;
    token("R5 SETUP under stall", 2, DEV, 0);
    data("R5 SETUP ACK", 5, 1, 1);
    token("R5 stall cleared", 1, DEV, 0);

    token("R9 OUT", 0, DEV, 0);
    data("R9 bad CRC", 4, 1, 0);
    token("R9 OUT", 0, DEV, 0);
    data("R9 nine bytes", 9, 1, 1);

    token("R1 foreign address", 1, 7'h11, 0);
    token("R1 foreign OUT", 0, 7'h00, 0);
    data("R1 data ignored", 2, 1, 1);

    token("R2 EP1 disabled", 1, DEV, 1);
    token("R2 SETUP to EP1", 2, DEV, 1);
    wr_en(6'b111_111);
    token("R2 EP3 ignored", 1, DEV, 3);
    in_loaded = 3'b100;
    token("R3 EP2 send", 1, DEV, 2);
    ack("R4 EP2 done shared");
    token("R3 EP1 NAK", 1, DEV, 1);
    token("R8 EP2 OUT", 0, DEV, 2);
    data("R8 EP2 record", 6, 1, 1);
    wr_stall(4'b0100);
    token("R7 EP1 IN stall", 1, DEV, 1);
    token("R7 EP1 OUT", 0, DEV, 1);
    data("R7 EP1 OUT stall", 1, 0, 1);
    in_loaded = 3'b001;
    token("R4 send no ack", 1, DEV, 0);
    token("R4 intervening token", 1, DEV, 1);
    ack("R4 late ack ignored");

    for (int i = 0; i < 400; i++) begin
      int r, pid, addr, ep;
      @(negedge clk);
      out_busy  = ($urandom % 4) == 0;
      in_loaded = 3'($urandom);
      r = $urandom % 16;
      if (r == 0) wr_stall(($urandom % 3 == 0) ? 4'($urandom) : 4'b0000);
      else if (r == 1) wr_en(6'($urandom) | 6'b001001);
      else if (r == 2) clr("R10 random clear", 2'($urandom), 1'($urandom));
      else if (r == 3) do_bus_reset();
      else begin
        pid  = $urandom % 4;
        addr = ($urandom % 6 == 0) ? int'($urandom % 128) : DEV;
        ep   = $urandom % 4;
        token("R1/R2/R3/R5/R7 random token", pid, addr, ep);
        if (pid != 1) begin
          if ($urandom % 5 != 0)
            data("R6/R7/R8/R9 random data", int'($urandom % 11), 1'($urandom),
                 ($urandom % 6) != 0);
        end else if ($urandom % 4 != 0) ack("R4 random ack");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule